// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date as packed BCD counters: seconds, minutes and hours in one word, day of month, month and a two-digit year past 2000 in another, plus a binary weekday index. An external base tick advances it. A fixed number of base ticks, set by a parameter, makes one second. The clock stays frozen until software writes a specific 32-bit arming word. After that it counts in 24-hour form, applies month lengths and leap years, and wraps the year from 99 to 00.

Software uses a plain 32-bit register port. It has a write strobe, a byte offset, write data and combinational read data. A write is taken on the clock edge where the strobe is high. There is no back-pressure: the port accepts an access in every cycle, and read data reflect the addressed register in the same cycle. Two event sources feed one interrupt line. The first is a calendar alarm that matches time and date. The second is a once-per-second update. Each source has an enable bit and a sticky status flag that is cleared by writing 1.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time word reads 0x000000, the date word reads 0x000101 (day 01, month 01, year 00), and the weekday reads 0. The arming, enable, status and both alarm registers read 0, and `irq` is low.
- R2: Writing 0xA5EB1357 to offset 0x00 activates the clock, and bit 0 of offset 0x00 then reads 1. A write of any other value to that offset leaves an inactive clock inactive. Once active, the clock stays active until reset.
- R3: While inactive, base ticks change neither time, date, weekday nor status.
- R4: While active, the seconds advance once for every SUB_TICKS base ticks. A write to the time word (0x0C) or the date word (0x10) loads the value and discards any partly counted second.
- R5: The time word at 0x0C holds BCD seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16, and bits 31:24 read 0. Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00.
- R6: At the hour wrap the day of month (date bits 7:0) advances. It returns to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02.
- R7: In month 02 the day wraps after 29 when the year offset (date bits 23:16) is divisible by 4, and after 28 otherwise. Bit 0 of offset 0x24 reads 1 exactly when the current year is a leap year.
- R8: The month (date bits 15:8) wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: The weekday at 0x18 is a binary index from 0 to 6. It steps at each day rollover and wraps from 6 to 0, and a write loads it.
- R10: Status bit 1 at 0x2C is set on every elapsed second. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: Status bit 0 is set at the second where the new time equals the alarm time word (0x1C) and the new date equals the alarm date word (0x20). Both alarm words use the layouts of the time and date words. A time match on a different date does not set the bit.
- R12: `irq` is high exactly when some status bit and the enable bit in the same position at 0x28 are both 1.
- R13: Bit 0 of the format register at 0x14 always reads 1 (24-hour form), and writes to that register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Base tick pulse, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong carry decision shows in the time or date word on the clock edge after the affected second. A wrong leap or month-length rule shows only when a day rollover hits that month, so the vectors start one second before each such boundary. A wrong sub-second phase shifts every later second by whole base ticks and appears at the first second after a reload. Status and alarm faults show on `irq` and on the status word in the cycle after the second elapses.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int WD_W    = 3;
  localparam int IRQ_SRC = 2;
  localparam int SRC_ALM = 0;
  localparam int SRC_UPD = 1;

  localparam logic [ADDR_W-1:0] OFS_ARM  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_TIME = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_DATE = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_FMT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_WDAY = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_TALM = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DALM = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_LEAP = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_ISTS = 6'h2C;

  localparam logic [DATA_W-1:0] ARM_WORD = 32'hA5EB1357;
  localparam logic [WD_W-1:0]   WD_LAST  = 3'd6;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } hms_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
  } ymd_t;

  // next value of a two-digit packed BCD field, no upper wrap
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year offset divisible by four
  function automatic logic bcd_leap(input logic [7:0] y);
    return ((8'(y[7:4]) * 8'd10 + 8'(y[3:0])) % 8'd4) == 8'd0;
  endfunction

  // last day of a BCD month
  function automatic logic [7:0] month_end(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int SUB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic tick_in,
  output logic sec_evt
);
  localparam int CW = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUB_TICKS - 1);

  logic [CW-1:0] phase_q;

  assign sec_evt = en & tick_in & ~restart & (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            phase_q <= '0;
    else if (restart)      phase_q <= '0;
    else if (en & tick_in) phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
  end
endmodule

// File: rtl/rtc_hms.sv
module rtc_hms
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  input  hms_t load_val,
  output hms_t now_q,
  output hms_t nxt,
  output logic day_end
);
  always_comb begin
    nxt     = now_q;
    day_end = 1'b0;
    if (now_q.sc >= 8'h59) begin
      nxt.sc = 8'h00;
      if (now_q.mn >= 8'h59) begin
        nxt.mn = 8'h00;
        if (now_q.hr >= 8'h23) begin
          nxt.hr  = 8'h00;
          day_end = 1'b1;
        end else begin
          nxt.hr = bcd_step(now_q.hr);
        end
      end else begin
        nxt.mn = bcd_step(now_q.mn);
      end
    end else begin
      nxt.sc = bcd_step(now_q.sc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    now_q <= '0;
    else if (load) now_q <= load_val;
    else if (step) now_q <= nxt;
  end
endmodule

// File: rtl/rtc_ymd.sv
module rtc_ymd
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            load,
  input  ymd_t            load_val,
  input  logic            wd_load,
  input  logic [WD_W-1:0] wd_val,
  output ymd_t            date_q,
  output ymd_t            nxt,
  output logic [WD_W-1:0] wd_q,
  output logic            leap
);
  localparam ymd_t DATE_RST = '{yr: 8'h00, mo: 8'h01, dy: 8'h01};

  assign leap = bcd_leap(date_q.yr);

  always_comb begin
    nxt = date_q;
    if (date_q.dy >= month_end(date_q.mo, leap)) begin
      nxt.dy = 8'h01;
      if (date_q.mo >= 8'h12) begin
        nxt.mo = 8'h01;
        nxt.yr = (date_q.yr >= 8'h99) ? 8'h00 : bcd_step(date_q.yr);
      end else begin
        nxt.mo = bcd_step(date_q.mo);
      end
    end else begin
      nxt.dy = bcd_step(date_q.dy);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    date_q <= DATE_RST;
    else if (load) date_q <= load_val;
    else if (step) date_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wd_q <= '0;
    else if (wd_load) wd_q <= wd_val;
    else if (step)    wd_q <= (wd_q >= WD_LAST) ? '0 : wd_q + WD_W'(1);
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int SUB_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic               active_q;
  logic               sec_evt;
  logic               hms_wrap;
  logic               day_step;
  logic               alm_hit;
  hms_t               hms_q, hms_nxt;
  ymd_t               ymd_q, ymd_nxt;
  logic [WD_W-1:0]    wd_q;
  logic               leap;
  logic [23:0]        talm_q, dalm_q;
  logic [IRQ_SRC-1:0] ien_q, sts_q, sts_set;

  logic wr_arm, wr_time, wr_date, wr_wday, wr_talm, wr_dalm, wr_ien, wr_sts;
  assign wr_arm  = bus_we && (bus_addr == OFS_ARM);
  assign wr_time = bus_we && (bus_addr == OFS_TIME);
  assign wr_date = bus_we && (bus_addr == OFS_DATE);
  assign wr_wday = bus_we && (bus_addr == OFS_WDAY);
  assign wr_talm = bus_we && (bus_addr == OFS_TALM);
  assign wr_dalm = bus_we && (bus_addr == OFS_DALM);
  assign wr_ien  = bus_we && (bus_addr == OFS_IEN);
  assign wr_sts  = bus_we && (bus_addr == OFS_ISTS);

  always_ff @(posedge clk) begin
    if (!rst_n)                                active_q <= 1'b0;
    else if (wr_arm && bus_wdata == ARM_WORD) active_q <= 1'b1;
  end

  rtc_prescale #(.SUB_TICKS(SUB_TICKS)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (active_q),
    .restart (wr_time | wr_date),
    .tick_in (tick_in),
    .sec_evt (sec_evt)
  );

  rtc_hms u_hms (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (sec_evt),
    .load     (wr_time),
    .load_val (hms_t'(bus_wdata[23:0])),
    .now_q    (hms_q),
    .nxt      (hms_nxt),
    .day_end  (hms_wrap)
  );

  assign day_step = sec_evt & hms_wrap;

  rtc_ymd u_ymd (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (day_step),
    .load     (wr_date),
    .load_val (ymd_t'(bus_wdata[23:0])),
    .wd_load  (wr_wday),
    .wd_val   (bus_wdata[WD_W-1:0]),
    .date_q   (ymd_q),
    .nxt      (ymd_nxt),
    .wd_q     (wd_q),
    .leap     (leap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      talm_q <= '0;
      dalm_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_talm) talm_q <= bus_wdata[23:0];
      if (wr_dalm) dalm_q <= bus_wdata[23:0];
      if (wr_ien)  ien_q  <= bus_wdata[IRQ_SRC-1:0];
    end
  end

  // compare against the values the counters take on this edge
  assign alm_hit = sec_evt && (hms_nxt == talm_q) &&
                   ((hms_wrap ? ymd_nxt : ymd_q) == dalm_q);

  always_comb begin
    sts_set          = '0;
    sts_set[SRC_ALM] = alm_hit;
    sts_set[SRC_UPD] = sec_evt;
  end

  for (genvar i = 0; i < IRQ_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= sts_set[i] | (sts_q[i] & ~(wr_sts & bus_wdata[i]));
    end
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ARM:  bus_rdata = {{(DATA_W-1){1'b0}}, active_q};
      OFS_TIME: bus_rdata = {8'h00, hms_q};
      OFS_DATE: bus_rdata = {8'h00, ymd_q};
      OFS_FMT:  bus_rdata = {{(DATA_W-1){1'b0}}, 1'b1};
      OFS_WDAY: bus_rdata = {{(DATA_W-WD_W){1'b0}}, wd_q};
      OFS_TALM: bus_rdata = {8'h00, talm_q};
      OFS_DALM: bus_rdata = {8'h00, dalm_q};
      OFS_LEAP: bus_rdata = {{(DATA_W-1){1'b0}}, leap};
      OFS_IEN:  bus_rdata = {{(DATA_W-IRQ_SRC){1'b0}}, ien_q};
      OFS_ISTS: bus_rdata = {{(DATA_W-IRQ_SRC){1'b0}}, sts_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import rtc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               active_q,
  input logic               sec_evt,
  input logic [23:0]        hms_q,
  input logic [IRQ_SRC-1:0] sts_q,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata
);
  p_arm_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_ARM && bus_wdata == ARM_WORD) |=> active_q);

  p_stay_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);

  p_idle_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(bus_we && bus_addr == OFS_TIME)) |=> $stable(hms_q));

  p_midnight_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && hms_q == 24'h235959) |=> (hms_q == 24'h000000));

  p_update_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> sts_q[SRC_UPD]);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[SRC_UPD] && !(bus_we && bus_addr == OFS_ISTS && bus_wdata[SRC_UPD]))
      |=> sts_q[SRC_UPD]);

  p_alarm_on_second_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[SRC_ALM]) |-> $past(sec_evt));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active_q  (active_q),
  .sec_evt   (sec_evt),
  .hms_q     (hms_q),
  .sts_q     (sts_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;
  localparam int ST = 4;
  localparam logic [5:0] A_ARM = 6'h00, A_TIME = 6'h0C, A_DATE = 6'h10, A_FMT = 6'h14,
                         A_WDAY = 6'h18, A_TALM = 6'h1C, A_DALM = 6'h20, A_LEAP = 6'h24,
                         A_IEN = 6'h28, A_ISTS = 6'h2C;
  localparam logic [31:0] ARM = 32'hA5EB1357;

  // fields: start time, start date, start weekday, seconds, end time, end date, end weekday
  localparam int NV = 12;
  localparam logic [109:0] VECS [NV] = '{
    {24'h123456, 24'h230615, 3'd2, 8'd1, 24'h123457, 24'h230615, 3'd2}, // R5
    {24'h000059, 24'h000101, 3'd0, 8'd1, 24'h000100, 24'h000101, 3'd0}, // R5
    {24'h235959, 24'h230430, 3'd3, 8'd1, 24'h000000, 24'h230501, 3'd4}, // R6
    {24'h235959, 24'h230530, 3'd5, 8'd1, 24'h000000, 24'h230531, 3'd6}, // R6
    {24'h235959, 24'h230531, 3'd6, 8'd1, 24'h000000, 24'h230601, 3'd0}, // R6 R9
    {24'h235959, 24'h230228, 3'd1, 8'd1, 24'h000000, 24'h230301, 3'd2}, // R7
    {24'h235959, 24'h240228, 3'd1, 8'd1, 24'h000000, 24'h240229, 3'd2}, // R7
    {24'h235959, 24'h240229, 3'd2, 8'd1, 24'h000000, 24'h240301, 3'd3}, // R7
    {24'h235959, 24'h991231, 3'd5, 8'd1, 24'h000000, 24'h000101, 3'd6}, // R8
    {24'h235959, 24'h231231, 3'd4, 8'd1, 24'h000000, 24'h240101, 3'd5}, // R8
    {24'h095958, 24'h231110, 3'd0, 8'd3, 24'h100001, 24'h231110, 3'd0}, // R5
    {24'h235958, 24'h230930, 3'd1, 8'd2, 24'h000000, 24'h231001, 3'd2}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  bcd_rtc #(.SUB_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1;
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 arm",   A_ARM,  32'h0);
    rd_chk("R1 time",  A_TIME, 32'h000000);
    rd_chk("R1 date",  A_DATE, 32'h000101);
    rd_chk("R1 wday",  A_WDAY, 32'h0);
    rd_chk("R1 ien",   A_IEN,  32'h0);
    rd_chk("R1 sts",   A_ISTS, 32'h0);
    rd_chk("R1 talm",  A_TALM, 32'h0);
    rd_chk("R1 dalm",  A_DALM, 32'h0);
    irq_chk("R1 irq", 1'b0);
    // R13 format reads 24-hour and ignores writes
    rd_chk("R13 fmt", A_FMT, 32'h1);
    wr(A_FMT, 32'h0);
    rd_chk("R13 fmt after write", A_FMT, 32'h1);

    // R3 inactive clock does not count
    wr(A_TIME, 32'h000005);
    ticks(3 * ST);
    rd_chk("R3 time frozen", A_TIME, 32'h000005);
    rd_chk("R3 no status",   A_ISTS, 32'h0);

    // R2 arming
    wr(A_ARM, 32'h12345678);
    rd_chk("R2 wrong word", A_ARM, 32'h0);
    ticks(ST);
    rd_chk("R2 still frozen", A_TIME, 32'h000005);
    wr(A_ARM, ARM);
    rd_chk("R2 armed", A_ARM, 32'h1);
    wr(A_ARM, 32'h0);
    rd_chk("R2 stays armed", A_ARM, 32'h1);

    // R4 sub-second phase
    wr(A_TIME, 32'h000000);
    ticks(ST - 1);
    rd_chk("R4 partial second", A_TIME, 32'h000000);
    ticks(1);
    rd_chk("R4 full second", A_TIME, 32'h000001);
    ticks(ST - 1);
    wr(A_TIME, 32'h000010);
    ticks(1);
    rd_chk("R4 phase restarted", A_TIME, 32'h000010);
    ticks(ST - 1);
    rd_chk("R4 second after reload", A_TIME, 32'h000011);

    // R5 upper bits read zero
    wr(A_TIME, 32'hFF123456);
    rd_chk("R5 packing", A_TIME, 32'h00123456);

    // R5 R6 R7 R8 R9 R13 counting vectors
    for (int i = 0; i < NV; i++) begin
      logic [109:0] v;
      v = VECS[i];
      wr(A_DATE, {8'h00, v[85:62]});
      wr(A_TIME, {8'h00, v[109:86]});
      wr(A_WDAY, {29'h0, v[61:59]});
      ticks(int'(v[58:51]) * ST);
      rd_chk($sformatf("R5/R6/R7/R8 vec%0d time", i), A_TIME, {8'h00, v[50:27]});
      rd_chk($sformatf("R6/R7/R8 vec%0d date", i), A_DATE, {8'h00, v[26:3]});
      rd_chk($sformatf("R9 vec%0d weekday", i), A_WDAY, {29'h0, v[2:0]});
    end

    // R7 leap indicator
    wr(A_DATE, 32'h240101);
    rd_chk("R7 leap 24", A_LEAP, 32'h1);
    wr(A_DATE, 32'h230101);
    rd_chk("R7 leap 23", A_LEAP, 32'h0);
    wr(A_DATE, 32'h000101);
    rd_chk("R7 leap 00", A_LEAP, 32'h1);

    // R10 update flag, write-one-to-clear
    wr(A_ISTS, 32'h3);
    rd_chk("R10 cleared", A_ISTS, 32'h0);
    ticks(ST);
    rd_chk("R10 set by second", A_ISTS, 32'h2);
    wr(A_ISTS, 32'h0);
    rd_chk("R10 zero write no effect", A_ISTS, 32'h2);
    // R12 gating
    irq_chk("R12 disabled", 1'b0);
    wr(A_IEN, 32'h2);
    irq_chk("R12 enabled", 1'b1);
    wr(A_IEN, 32'h1);
    irq_chk("R12 other enable", 1'b0);
    wr(A_ISTS, 32'h2);
    rd_chk("R10 one write clears", A_ISTS, 32'h0);
    wr(A_IEN, 32'h0);

    // R11 alarm on matching time and date
    wr(A_DATE, 32'h240101);
    wr(A_TIME, 32'h080000);
    wr(A_TALM, 32'h080002);
    wr(A_DALM, 32'h240101);
    wr(A_ISTS, 32'h3);
    ticks(ST);
    rd_chk("R11 not yet", A_ISTS, 32'h2);
    ticks(ST);
    rd_chk("R11 alarm set", A_ISTS, 32'h3);
    irq_chk("R12 alarm masked", 1'b0);
    wr(A_IEN, 32'h1);
    irq_chk("R12 alarm raises irq", 1'b1);
    wr(A_ISTS, 32'h1);
    irq_chk("R12 cleared irq", 1'b0);
    rd_chk("R10 alarm clear keeps update", A_ISTS, 32'h2);

    // R11 date mismatch gives no alarm
    wr(A_DALM, 32'h240102);
    wr(A_TIME, 32'h080000);
    ticks(2 * ST);
    rd_chk("R11 date mismatch", A_ISTS, 32'h2);

    // R11 alarm across midnight uses the new date
    wr(A_DATE, 32'h240228);
    wr(A_TIME, 32'h235959);
    wr(A_TALM, 32'h000000);
    wr(A_DALM, 32'h240229);
    wr(A_ISTS, 32'h3);
    ticks(ST);
    rd_chk("R11 midnight alarm", A_ISTS, 32'h3);
    irq_chk("R12 midnight irq", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule